// File: doc/BRIEF.md
# DMA Controller Configuration Register Bank

This block holds the configuration of a four-channel DMA controller and its attached CRC unit, behind a small synchronous register interface. Software writes a word by presenting an address, write data and a one-cycle write strobe. The word is captured at the next rising clock edge. Read data is a combinational function of the address and always reflects the current register contents. The bank drives the DMA and CRC enables, the arbiter priority-level enables, the two base addresses, the CRC settings and every channel's settings straight to the transfer engine.

Some fields are write-protected, and the guard for each one is the enable of the unit that uses it. The base addresses are locked while the DMA is enabled. The CRC settings are locked while the CRC is enabled. The global soft reset is locked while either the DMA or the CRC is enabled. A channel's command field, arbitration level and soft reset are locked while that channel is enabled. Channels are reached indirectly: a channel-select register chooses which channel the two per-channel addresses reach. Protection is judged on the enable values held before the write's clock edge. A blocked field keeps its value, and the other fields in the same word still take the written data.

Top module: `dmacfg_regbank`

## Requirements
- R1: After the synchronous reset `rst`, every register reads zero and every output is zero.
- R2: Address 1 (descriptor base) and address 2 (write-back base) take a write only while the DMA enable is 0. Bits [3:0] of both always read zero.
- R3: Address 0 holds the control word: bit 0 is the global soft reset, bit 1 is the DMA enable, bit 2 is the CRC enable, and bits [11:8] are the priority-level enables. A write of 1 to bit 0 is taken only if the DMA enable and the CRC enable are both 0. Once taken, every register in the bank, including all channel registers, is zero one clock later. Writes presented in the cycle the soft reset is pending are discarded.
- R4: Address 3 (CRC mode, bits [9:0]) and address 4 (CRC seed, 32 bits) take a write only while the CRC enable is 0.
- R5: At address 7, the command field (bits [11:10]) and the arbitration level (bits [9:8]) of the selected channel take a write only while that channel's enable is 0.
- R6: At address 6, bit 1 is the channel enable and bit 0 is the channel soft reset. The soft-reset bit is taken only while the channel's enable is 0. Once taken, that channel's registers alone are zero one clock later, and writes to that channel in the pending cycle are discarded.
- R7: Address 5 holds an 8-bit channel select. Addresses 6 and 7 read and write the channel it names.
- R8: While the channel select is 4 or more, addresses 6 and 7 read zero and writes to them change no channel.
- R9: A write that hits a locked field still updates the unlocked fields of the same word. These are the enables and level enables at address 0, the channel enable at address 6, and the trigger action (bits [1:0]) and trigger source (bits [7:2]) at address 7.
- R10: Read data always returns the current contents of the addressed register. Unused bits and unmapped addresses (8 to 15) read zero.
- R11: The priority-level enables, base addresses, CRC settings and per-channel fields appear on the outputs in the cycle after the write that sets them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_rdata | output | 32 | Read data for bus_addr |
| dma_enable | output | 1 | Global DMA enable |
| crc_enable | output | 1 | CRC unit enable |
| prio_lvl_en | output | 4 | Arbiter priority-level enables |
| desc_base | output | 32 | Descriptor base address |
| wb_base | output | 32 | Write-back base address |
| crc_mode | output | 10 | CRC mode setting |
| crc_seed | output | 32 | CRC seed |
| ch_enable | output | 4 | Per-channel enables |
| ch_trig_act | output | 8 | Trigger action, 2 bits per channel |
| ch_trig_src | output | 24 | Trigger source, 6 bits per channel |
| ch_arb_lvl | output | 8 | Arbitration level, 2 bits per channel |
| ch_cmd | output | 8 | Channel command, 2 bits per channel |

## Verification
The lock assertions assume that only the bus can change a locked field and that a soft reset can clear it. The bench therefore drives only port-level writes and resets, so no state changes through any other path. The stability checks rest on the fact that a soft-reset bit can only be set while its unit is disabled. The bench deliberately writes words with the soft-reset bit and the enable bit set together, to cover the case where a reset becomes pending while the enable also goes high. In the random phase the global soft-reset bit is set only rarely, so that protected states last long enough to be hit by locked writes. The channel select spans values beyond the channel count.

// File: rtl/dmacfg_pkg.sv
package dmacfg_pkg;
    parameter int NUM_CH     = 4;
    parameter int NUM_LVL    = 4;
    parameter int AW         = 4;
    parameter int DW         = 32;
    parameter int TA_W       = 2;
    parameter int TS_W       = 6;
    parameter int LV_W       = 2;
    parameter int CMD_W      = 2;
    parameter int CRCM_W     = 10;
    parameter int CHID_W     = 8;
    parameter int BASE_ALIGN = 4;
    localparam int CH_IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    localparam logic [AW-1:0] A_CTRL = AW'(0);
    localparam logic [AW-1:0] A_DESC = AW'(1);
    localparam logic [AW-1:0] A_WB   = AW'(2);
    localparam logic [AW-1:0] A_CRCM = AW'(3);
    localparam logic [AW-1:0] A_SEED = AW'(4);
    localparam logic [AW-1:0] A_CHID = AW'(5);
    localparam logic [AW-1:0] A_CHA  = AW'(6);
    localparam logic [AW-1:0] A_CHB  = AW'(7);

    typedef struct packed {
        logic [NUM_LVL-1:0] lvl_en;
        logic [4:0]         rsv;
        logic               crc_en;
        logic               dma_en;
        logic               swrst;
    } ctrl_t;

    typedef struct packed {
        logic en;
        logic swrst;
    } cha_t;

    typedef struct packed {
        logic [CMD_W-1:0] cmd;
        logic [LV_W-1:0]  lvl;
        logic [TS_W-1:0]  src;
        logic [TA_W-1:0]  act;
    } chb_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int CHA_W  = $bits(cha_t);
    localparam int CHB_W  = $bits(chb_t);

    function automatic logic [DW-1:0] align_base(input logic [DW-1:0] v);
        logic [DW-1:0] r;
        r = v;
        r[BASE_ALIGN-1:0] = '0;
        return r;
    endfunction
endpackage

// File: rtl/dmacfg_global.sv
module dmacfg_global
    import dmacfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    output ctrl_t             ctrl_q,
    output logic [DW-1:0]     desc_q,
    output logic [DW-1:0]     wb_q,
    output logic [CRCM_W-1:0] crcm_q,
    output logic [DW-1:0]     seed_q,
    output logic [CHID_W-1:0] chid_q
);
    ctrl_t wctrl;
    logic  dma_free;
    logic  crc_free;

    assign wctrl    = ctrl_t'(wdata[CTRL_W-1:0]);
    assign dma_free = !ctrl_q.dma_en;
    assign crc_free = !ctrl_q.crc_en;

    always_ff @(posedge clk) begin
        if (rst || ctrl_q.swrst) begin
            ctrl_q <= '0;
            desc_q <= '0;
            wb_q   <= '0;
            crcm_q <= '0;
            seed_q <= '0;
            chid_q <= '0;
        end else if (we) begin
            case (addr)
                A_CTRL: begin
                    ctrl_q.dma_en <= wctrl.dma_en;
                    ctrl_q.crc_en <= wctrl.crc_en;
                    ctrl_q.lvl_en <= wctrl.lvl_en;
                    if (dma_free && crc_free) ctrl_q.swrst <= wctrl.swrst;
                end
                A_DESC: if (dma_free) desc_q <= align_base(wdata);
                A_WB:   if (dma_free) wb_q   <= align_base(wdata);
                A_CRCM: if (crc_free) crcm_q <= wdata[CRCM_W-1:0];
                A_SEED: if (crc_free) seed_q <= wdata;
                A_CHID: chid_q <= wdata[CHID_W-1:0];
                default: ;
            endcase
        end
    end

    assert_base_locked_R2: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.dma_en && !ctrl_q.swrst) |=> ($stable(desc_q) && $stable(wb_q)));
    assert_base_aligned_R2: assert property (@(posedge clk) disable iff (rst)
        (desc_q[BASE_ALIGN-1:0] == '0) && (wb_q[BASE_ALIGN-1:0] == '0));
    assert_swrst_locked_R3: assert property (@(posedge clk) disable iff (rst)
        ((ctrl_q.dma_en || ctrl_q.crc_en) && !ctrl_q.swrst) |=> !ctrl_q.swrst);
    assert_swrst_clears_R3: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.swrst |=> (ctrl_q == '0 && desc_q == '0 && wb_q == '0 &&
                          crcm_q == '0 && seed_q == '0 && chid_q == '0));
    assert_crc_locked_R4: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.crc_en && !ctrl_q.swrst) |=> ($stable(crcm_q) && $stable(seed_q)));
endmodule

// File: rtl/dmacfg_chan.sv
module dmacfg_chan
    import dmacfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_a,
    input  logic              wr_b,
    input  logic [CHB_W-1:0]  wdata,
    output cha_t              a_q,
    output chb_t              b_q
);
    chb_t wb;
    cha_t wa;

    assign wb = chb_t'(wdata);
    assign wa = cha_t'(wdata[CHA_W-1:0]);

    always_ff @(posedge clk) begin
        if (rst || a_q.swrst) begin
            a_q <= '0;
            b_q <= '0;
        end else begin
            if (wr_a) begin
                a_q.en <= wa.en;
                if (!a_q.en) a_q.swrst <= wa.swrst;
            end
            if (wr_b) begin
                b_q.act <= wb.act;
                b_q.src <= wb.src;
                if (!a_q.en) begin
                    b_q.cmd <= wb.cmd;
                    b_q.lvl <= wb.lvl;
                end
            end
        end
    end

    assert_chan_locked_R5: assert property (@(posedge clk) disable iff (rst)
        (a_q.en && !a_q.swrst) |=> ($stable(b_q.cmd) && $stable(b_q.lvl)));
    assert_chan_swrst_locked_R6: assert property (@(posedge clk) disable iff (rst)
        (a_q.en && !a_q.swrst) |=> !a_q.swrst);
    assert_chan_swrst_clears_R6: assert property (@(posedge clk) disable iff (rst)
        a_q.swrst |=> (a_q == '0 && b_q == '0));
    assert_chan_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (!wr_a && !wr_b && !a_q.swrst) |=> ($stable(a_q) && $stable(b_q)));
endmodule

// File: rtl/dmacfg_rdmux.sv
module dmacfg_rdmux
    import dmacfg_pkg::*;
(
    input  logic [AW-1:0]        addr,
    input  ctrl_t                ctrl_q,
    input  logic [DW-1:0]        desc_q,
    input  logic [DW-1:0]        wb_q,
    input  logic [CRCM_W-1:0]    crcm_q,
    input  logic [DW-1:0]        seed_q,
    input  logic [CHID_W-1:0]    chid_q,
    input  cha_t [NUM_CH-1:0]    cha,
    input  chb_t [NUM_CH-1:0]    chb,
    output logic [DW-1:0]        rdata
);
    logic                chid_ok;
    logic [CH_IDX_W-1:0] idx;

    assign chid_ok = (chid_q < CHID_W'(NUM_CH));
    assign idx     = chid_q[CH_IDX_W-1:0];

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: rdata = DW'(ctrl_q);
            A_DESC: rdata = desc_q;
            A_WB:   rdata = wb_q;
            A_CRCM: rdata = DW'(crcm_q);
            A_SEED: rdata = seed_q;
            A_CHID: rdata = DW'(chid_q);
            A_CHA:  if (chid_ok) rdata = DW'(cha[idx]);
            A_CHB:  if (chid_ok) rdata = DW'(chb[idx]);
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/dmacfg_regbank.sv
module dmacfg_regbank
    import dmacfg_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [AW-1:0]            bus_addr,
    input  logic [DW-1:0]            bus_wdata,
    input  logic                     bus_we,
    output logic [DW-1:0]            bus_rdata,
    output logic                     dma_enable,
    output logic                     crc_enable,
    output logic [NUM_LVL-1:0]       prio_lvl_en,
    output logic [DW-1:0]            desc_base,
    output logic [DW-1:0]            wb_base,
    output logic [CRCM_W-1:0]        crc_mode,
    output logic [DW-1:0]            crc_seed,
    output logic [NUM_CH-1:0]        ch_enable,
    output logic [NUM_CH*TA_W-1:0]   ch_trig_act,
    output logic [NUM_CH*TS_W-1:0]   ch_trig_src,
    output logic [NUM_CH*LV_W-1:0]   ch_arb_lvl,
    output logic [NUM_CH*CMD_W-1:0]  ch_cmd
);
    ctrl_t             ctrl_q;
    logic [CHID_W-1:0] chid_q;
    cha_t [NUM_CH-1:0] cha;
    chb_t [NUM_CH-1:0] chb;
    logic              ch_rst;

    assign ch_rst = rst || ctrl_q.swrst;

    dmacfg_global u_global (
        .clk    (clk),
        .rst    (rst),
        .we     (bus_we),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .ctrl_q (ctrl_q),
        .desc_q (desc_base),
        .wb_q   (wb_base),
        .crcm_q (crc_mode),
        .seed_q (crc_seed),
        .chid_q (chid_q)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic hit;
        assign hit = bus_we && (chid_q == CHID_W'(c));
        dmacfg_chan u_chan (
            .clk   (clk),
            .rst   (ch_rst),
            .wr_a  (hit && (bus_addr == A_CHA)),
            .wr_b  (hit && (bus_addr == A_CHB)),
            .wdata (bus_wdata[CHB_W-1:0]),
            .a_q   (cha[c]),
            .b_q   (chb[c])
        );
        assign ch_enable[c]                    = cha[c].en;
        assign ch_trig_act[c*TA_W +: TA_W]     = chb[c].act;
        assign ch_trig_src[c*TS_W +: TS_W]     = chb[c].src;
        assign ch_arb_lvl[c*LV_W +: LV_W]      = chb[c].lvl;
        assign ch_cmd[c*CMD_W +: CMD_W]        = chb[c].cmd;
    end

    dmacfg_rdmux u_rdmux (
        .addr   (bus_addr),
        .ctrl_q (ctrl_q),
        .desc_q (desc_base),
        .wb_q   (wb_base),
        .crcm_q (crc_mode),
        .seed_q (crc_seed),
        .chid_q (chid_q),
        .cha    (cha),
        .chb    (chb),
        .rdata  (bus_rdata)
    );

    assign dma_enable  = ctrl_q.dma_en;
    assign crc_enable  = ctrl_q.crc_en;
    assign prio_lvl_en = ctrl_q.lvl_en;

    assert_oob_write_R8: assert property (@(posedge clk) disable iff (ch_rst)
        (chid_q >= CHID_W'(NUM_CH)) |=> $stable(cha) && $stable(chb));
endmodule

// File: tb/dmacfg_regbank_tb.sv
module dmacfg_regbank_tb;
    localparam int CLK_P = 10;

    logic        clk = 0;
    logic        rst = 1;
    logic [3:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic        bus_we = 0;
    logic [31:0] bus_rdata;
    logic        dma_enable, crc_enable;
    logic [3:0]  prio_lvl_en;
    logic [31:0] desc_base, wb_base, crc_seed;
    logic [9:0]  crc_mode;
    logic [3:0]  ch_enable;
    logic [7:0]  ch_trig_act, ch_arb_lvl, ch_cmd;
    logic [23:0] ch_trig_src;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    dmacfg_regbank u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .dma_enable(dma_enable),
        .crc_enable(crc_enable), .prio_lvl_en(prio_lvl_en), .desc_base(desc_base),
        .wb_base(wb_base), .crc_mode(crc_mode), .crc_seed(crc_seed),
        .ch_enable(ch_enable), .ch_trig_act(ch_trig_act), .ch_trig_src(ch_trig_src),
        .ch_arb_lvl(ch_arb_lvl), .ch_cmd(ch_cmd)
    );

    // behavioural reference model
    logic        m_sw, m_dma, m_crc;
    logic [3:0]  m_lvl;
    logic [31:0] m_desc, m_wb, m_seed;
    logic [9:0]  m_crcm;
    logic [7:0]  m_chid;
    logic        m_cen [4];
    logic        m_csw [4];
    logic [1:0]  m_act [4];
    logic [5:0]  m_src [4];
    logic [1:0]  m_lv  [4];
    logic [1:0]  m_cmd [4];

    always @(posedge clk) begin
        if (rst || m_sw) begin
            m_sw <= 0; m_dma <= 0; m_crc <= 0; m_lvl <= 0;
            m_desc <= 0; m_wb <= 0; m_seed <= 0; m_crcm <= 0; m_chid <= 0;
            for (int c = 0; c < 4; c++) begin
                m_cen[c] <= 0; m_csw[c] <= 0; m_act[c] <= 0;
                m_src[c] <= 0; m_lv[c] <= 0; m_cmd[c] <= 0;
            end
        end else begin
            for (int c = 0; c < 4; c++) if (m_csw[c]) begin
                m_cen[c] <= 0; m_csw[c] <= 0; m_act[c] <= 0;
                m_src[c] <= 0; m_lv[c] <= 0; m_cmd[c] <= 0;
            end
            if (bus_we) begin
                if (bus_addr == 0) begin
                    m_dma <= bus_wdata[1]; m_crc <= bus_wdata[2]; m_lvl <= bus_wdata[11:8];
                    if (!m_dma && !m_crc) m_sw <= bus_wdata[0];
                end
                if (bus_addr == 1 && !m_dma) m_desc <= {bus_wdata[31:4], 4'h0};
                if (bus_addr == 2 && !m_dma) m_wb   <= {bus_wdata[31:4], 4'h0};
                if (bus_addr == 3 && !m_crc) m_crcm <= bus_wdata[9:0];
                if (bus_addr == 4 && !m_crc) m_seed <= bus_wdata;
                if (bus_addr == 5) m_chid <= bus_wdata[7:0];
                if (m_chid < 4 && !m_csw[m_chid[1:0]]) begin
                    if (bus_addr == 6) begin
                        m_cen[m_chid[1:0]] <= bus_wdata[1];
                        if (!m_cen[m_chid[1:0]]) m_csw[m_chid[1:0]] <= bus_wdata[0];
                    end
                    if (bus_addr == 7) begin
                        m_act[m_chid[1:0]] <= bus_wdata[1:0];
                        m_src[m_chid[1:0]] <= bus_wdata[7:2];
                        if (!m_cen[m_chid[1:0]]) begin
                            m_lv[m_chid[1:0]]  <= bus_wdata[9:8];
                            m_cmd[m_chid[1:0]] <= bus_wdata[11:10];
                        end
                    end
                end
            end
        end
    end

    function automatic logic [31:0] exp_rd(input logic [3:0] a);
        logic [31:0] r = 0;
        case (a)
            0: r = {20'h0, m_lvl, 5'h0, m_crc, m_dma, m_sw};
            1: r = m_desc;
            2: r = m_wb;
            3: r = {22'h0, m_crcm};
            4: r = m_seed;
            5: r = {24'h0, m_chid};
            6: if (m_chid < 4) r = {30'h0, m_cen[m_chid[1:0]], m_csw[m_chid[1:0]]};
            7: if (m_chid < 4) r = {20'h0, m_cmd[m_chid[1:0]], m_lv[m_chid[1:0]],
                                    m_src[m_chid[1:0]], m_act[m_chid[1:0]]};
            default: r = 0;
        endcase
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            check("R10 rdata", bus_rdata, exp_rd(bus_addr));
            check("R3 dma_enable", {31'h0, dma_enable}, {31'h0, m_dma});
            check("R4 crc_enable", {31'h0, crc_enable}, {31'h0, m_crc});
            check("R11 prio_lvl_en", {28'h0, prio_lvl_en}, {28'h0, m_lvl});
            check("R2 desc_base", desc_base, m_desc);
            check("R2 wb_base", wb_base, m_wb);
            check("R4 crc_mode", {22'h0, crc_mode}, {22'h0, m_crcm});
            check("R4 crc_seed", crc_seed, m_seed);
            for (int c = 0; c < 4; c++) begin
                check("R9 ch_enable", {31'h0, ch_enable[c]}, {31'h0, m_cen[c]});
                check("R9 ch_trig_act", {30'h0, ch_trig_act[c*2 +: 2]}, {30'h0, m_act[c]});
                check("R9 ch_trig_src", {26'h0, ch_trig_src[c*6 +: 6]}, {26'h0, m_src[c]});
                check("R5 ch_arb_lvl", {30'h0, ch_arb_lvl[c*2 +: 2]}, {30'h0, m_lv[c]});
                check("R5 ch_cmd", {30'h0, ch_cmd[c*2 +: 2]}, {30'h0, m_cmd[c]});
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd(input string req, input logic [3:0] a, input logic [31:0] exp);
        bus_addr = a;
        #2;
        check(req, bus_rdata, exp);
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        for (int a = 0; a < 16; a++) rd("R1 reset value", a[3:0], 32'h0);

        wr(1, 32'h1234_5678); rd("R2 desc aligned", 1, 32'h1234_5670);
        wr(2, 32'hCAFE_F00F); rd("R2 wb aligned", 2, 32'hCAFE_F000);
        wr(0, 32'h0000_0A02); rd("R11 lvl_en and dma_en", 0, 32'h0000_0A02);
        wr(1, 32'hFFFF_FFFF); rd("R2 desc locked", 1, 32'h1234_5670);
        wr(0, 32'h0000_0503); rd("R3 swrst refused, R9 others taken", 0, 32'h0000_0502);
        wr(3, 32'h3FF); wr(4, 32'hDEAD_BEEF);
        wr(0, 32'h0000_0004);
        wr(3, 32'h0); rd("R4 crc mode locked", 3, 32'h3FF);
        wr(4, 32'h0); rd("R4 crc seed locked", 4, 32'hDEAD_BEEF);
        rd("R10 unmapped", 9, 32'h0);

        wr(5, 1); wr(7, 32'hFFF); rd("R7 ch1 written", 7, 32'hFFF);
        wr(6, 2); wr(7, 32'h000); rd("R5 ch1 cmd/lvl held, R9 act/src cleared", 7, 32'hF00);
        wr(5, 2); wr(7, 32'h555); rd("R7 ch2 written", 7, 32'h555);
        wr(5, 9); rd("R8 oob cha reads zero", 6, 0); rd("R8 oob chb reads zero", 7, 0);
        wr(7, 32'hFFF); wr(6, 3);
        wr(5, 2); rd("R8 ch2 untouched", 7, 32'h555); rd("R8 ch2 enable untouched", 6, 0);
        wr(5, 1); wr(6, 3); rd("R6 swrst refused while enabled", 6, 2);
        wr(6, 0); wr(6, 1);
        @(negedge clk);
        rd("R6 ch1 cleared", 7, 0);
        wr(5, 2); rd("R6 ch2 kept", 7, 32'h555);

        wr(0, 32'h0); wr(0, 32'h1);
        @(negedge clk);
        rd("R3 global swrst clears desc", 1, 0);
        rd("R3 global swrst clears ctrl", 0, 0);
        rd("R3 global swrst clears chid", 5, 0);
        rd("R3 global swrst clears ch0", 7, 0);

        for (int i = 0; i < 4000; i++) begin
            logic [3:0]  a;
            logic [31:0] d;
            a = 4'($urandom % 9);
            d = $urandom;
            if (a == 0 && ($urandom % 16) != 0) d[0] = 0;
            if (a == 5) d = $urandom % 6;
            if (a == 6 && ($urandom % 4) != 0) d[0] = 0;
            @(negedge clk);
            bus_addr = a; bus_wdata = d; bus_we = ($urandom % 3) != 0;
            if (($urandom % 500) == 0) rst = 1; else rst = 0;
        end
        @(negedge clk);
        bus_we = 0; rst = 0;
        repeat (3) @(negedge clk);
        summary();
    end
endmodule